// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block sits between the interrupt sources of a core and its exception logic. Each interrupt line is captured into a pending register. Level-type lines follow their request. Edge-type lines latch on a rising request and stay set until software clears them. Timer comparator matches also set the pending bits of fixed lines. The pending bits are qualified by an enable mask, and the non-maskable lines bypass that mask. A priority search then finds the highest interrupt level above the core's current level. That level is presented to the core together with a request flag.

Per-line configuration is fixed at elaboration. Parameters give the level of each line (`LINE_LEVEL`, 4 bits per line), the edge-type lines (`EDGE_MASK`), the non-maskable level (`NMI_LEVEL`) and the line driven by each timer (`TIMER_LINE`, 5 bits per timer). Every line whose level equals `NMI_LEVEL` is non-maskable.

The request output comes from a two-state machine. In `RES_IDLE`, the transition `go_assert` fires when the resolved level becomes nonzero. In `RES_ASSERT`, the transition `go_idle` fires when the resolved level returns to zero.

The default configuration is as follows:
- There are 8 lines and 5 levels, and `NMI_LEVEL` is 5.
- Lines 0..7 sit at levels 1,1,2,3,4,5,2,3.
- Lines 1, 6 and 7 are edge-type.
- Timer 0 drives line 6 and timer 1 drives line 7.
- The request port is 10 bits wide (`REQ_W` must exceed `NUM_LINES`).

Top module: `irq_level_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, the pending register, the enable mask and `irq_level` all become 0, and `irq_req` becomes 0.
- R2: Only lines that are both pending and enabled can be taken. A line at `NMI_LEVEL` is takeable whenever it is pending, whatever the state of its enable bit.
- R3: If `cur_level` is at or above `NMI_LEVEL`, it is treated as `NMI_LEVEL`-1, so a pending non-maskable line always resolves.
- R4: `irq_level` is the highest level L that meets both conditions: L is strictly above the (clamped) current level, and some takeable line is mapped to L. If no level qualifies, `irq_level` is 0.
- R5: `irq_req` is 1 exactly when `irq_level` is nonzero, through the states `RES_IDLE` and `RES_ASSERT`.
- R6: The pending bit of a level-type line equals that line's request as sampled at the previous edge. Dropping the request clears the bit.
- R7: The pending bit of an edge-type line is set by a low-to-high change of its request. It stays set after the request falls.
- R8: A `clr_we` with a 1 in `clr_mask` clears the pending bit of that edge-type line. A rising request on the same edge wins over the clear.
- R9: A pulse on `timer_hit[t]` sets the pending bit of the line mapped to timer t (default mapping: timer 0 to line 6, timer 1 to line 7).
- R10: Request bits at index `NUM_LINES` and above are ignored and change no state.
- R11: `pending` changes one edge after a request. `irq_level` and `irq_req` reflect the pending, enable and current-level values of the previous cycle, one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | REQ_W | Per-line request inputs; bits at index NUM_LINES and above are out of range |
| timer_hit | input | NUM_TIMERS | Timer comparator match pulses |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | NUM_LINES | New enable mask value |
| clr_we | input | 1 | Write strobe for the pending clear |
| clr_mask | input | NUM_LINES | Write-one-to-clear mask for edge-type pending bits |
| cur_level | input | 4 | Current interrupt level of the core |
| pending | output | NUM_LINES | Pending register |
| irq_level | output | 4 | Resolved pending level, 0 when none |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench targets four corner cases.
- Strict comparison with the current level: a resolver that used "at or above" would report level 4 while the core already sits at level 4.
- The non-maskable clamp: a design without it would stay silent on a non-maskable request while `cur_level` is 15.
- Set and clear in the same cycle: a wrong priority would lose a fresh edge interrupt that arrives together with an acknowledge.
- Line-type handling: an edge line that forgot its pulse would leave the pending bit clear, and a level line that latched would keep the request asserted after its source dropped.

The bench also toggles the out-of-range request bits, where any leak would disturb `pending`. It samples one edge after each stimulus, which would expose a resolver that drops or adds a pipeline stage.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
    localparam int LVL_W = 4;   // width of an interrupt level
    localparam int IDX_W = 5;   // width of a line index (up to 32 lines)

    typedef enum logic {
        RES_IDLE   = 1'b0,
        RES_ASSERT = 1'b1
    } res_state_e;
endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture
    import irq_res_pkg::*;
#(
    parameter int                          NUM_LINES  = 8,
    parameter int                          REQ_W      = 10,
    parameter int                          NUM_TIMERS = 2,
    parameter logic [NUM_LINES-1:0]        EDGE_MASK  = 8'hC2,
    parameter logic [NUM_TIMERS*IDX_W-1:0] TIMER_LINE = {5'd7, 5'd6}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REQ_W-1:0]      req_in,
    input  logic [NUM_TIMERS-1:0] timer_hit,
    input  logic                  clr_we,
    input  logic [NUM_LINES-1:0]  clr_mask,
    output logic [NUM_LINES-1:0]  pend_q
);
    logic [NUM_LINES-1:0] req_q;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] tset;
    logic [NUM_LINES-1:0] clr_eff;
    logic [NUM_LINES-1:0] pend_nxt;
    logic                 seen_q;

    assign rise    = req_in[NUM_LINES-1:0] & ~req_q;
    assign clr_eff = clr_we ? clr_mask : '0;

    // Route each comparator match onto its configured line.
    always_comb begin
        tset = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (timer_hit[t] && TIMER_LINE[t*IDX_W +: IDX_W] == IDX_W'(i)) begin
                    tset[i] = 1'b1;
                end
            end
        end
    end

    // Edge lines latch and honour clear (set wins); level lines track request.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (EDGE_MASK[i]) begin
                pend_nxt[i] = rise[i] | tset[i] | (pend_q[i] & ~clr_eff[i]);
            end else begin
                pend_nxt[i] = req_in[i] | tset[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            req_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            pend_q <= pend_nxt;
            req_q  <= req_in[NUM_LINES-1:0];
            seen_q <= 1'b1;
        end
    end

    // An edge-type pending bit not being cleared stays set.
    logic [NUM_LINES-1:0] keep_vec;
    assign keep_vec = pend_q & EDGE_MASK & ~clr_eff;

    assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (keep_vec != '0) |=> ((pend_q & $past(keep_vec)) == $past(keep_vec)));

    // Toggling only out-of-range request bits leaves the pending register alone.
    assert_oor_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $stable(req_in[NUM_LINES-1:0]) && !$stable(req_in[REQ_W-1:NUM_LINES])
         && timer_hit == '0 && $past(timer_hit) == '0 && !clr_we)
        |=> $stable(pend_q));
endmodule

// File: rtl/irq_level_search.sv
module irq_level_search
    import irq_res_pkg::*;
#(
    parameter int                         NUM_LINES  = 8,
    parameter int                         NUM_LEVELS = 5,
    parameter int                         NMI_LEVEL  = 5,
    parameter logic [NUM_LINES*LVL_W-1:0] LINE_LEVEL = 32'h3254_3211
) (
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] enable,
    input  logic [LVL_W-1:0]     cur_level,
    output logic [LVL_W-1:0]     lvl_nxt,
    output logic [LVL_W-1:0]     floor_lvl,
    output logic [NUM_LINES-1:0] nmi_lines
);
    logic [NUM_LINES-1:0] lvl_mask [1:NUM_LEVELS];
    logic [NUM_LINES-1:0] takeable;

    // Per-level membership table derived from the line-to-level map.
    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            assign lvl_mask[l][i] = (LINE_LEVEL[i*LVL_W +: LVL_W] == LVL_W'(l));
        end
    end

    assign nmi_lines = lvl_mask[NMI_LEVEL];
    assign takeable  = pend & (enable | nmi_lines);
    assign floor_lvl = (cur_level >= LVL_W'(NMI_LEVEL)) ? LVL_W'(NMI_LEVEL - 1) : cur_level;

    // Ascending scan: the last qualifying level is the highest.
    always_comb begin
        lvl_nxt = '0;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (LVL_W'(l) > floor_lvl && (lvl_mask[l] & takeable) != '0) begin
                lvl_nxt = LVL_W'(l);
            end
        end
    end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irq_res_pkg::*;
#(
    parameter int                          NUM_LINES  = 8,
    parameter int                          REQ_W      = 10,
    parameter int                          NUM_LEVELS = 5,
    parameter int                          NMI_LEVEL  = 5,
    parameter int                          NUM_TIMERS = 2,
    parameter logic [NUM_LINES*LVL_W-1:0]  LINE_LEVEL = 32'h3254_3211,
    parameter logic [NUM_LINES-1:0]        EDGE_MASK  = 8'hC2,
    parameter logic [NUM_TIMERS*IDX_W-1:0] TIMER_LINE = {5'd7, 5'd6}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REQ_W-1:0]      req_in,
    input  logic [NUM_TIMERS-1:0] timer_hit,
    input  logic                  en_we,
    input  logic [NUM_LINES-1:0]  en_wdata,
    input  logic                  clr_we,
    input  logic [NUM_LINES-1:0]  clr_mask,
    input  logic [LVL_W-1:0]      cur_level,
    output logic [NUM_LINES-1:0]  pending,
    output logic [LVL_W-1:0]      irq_level,
    output logic                  irq_req
);
    logic [NUM_LINES-1:0] en_q;
    logic [LVL_W-1:0]     lvl_nxt;
    logic [LVL_W-1:0]     floor_lvl;
    logic [NUM_LINES-1:0] nmi_lines;
    res_state_e           state_q, state_nxt;

    irq_pend_capture #(
        .NUM_LINES (NUM_LINES),
        .REQ_W     (REQ_W),
        .NUM_TIMERS(NUM_TIMERS),
        .EDGE_MASK (EDGE_MASK),
        .TIMER_LINE(TIMER_LINE)
    ) cap_i (
        .clk      (clk),
        .rst      (rst),
        .req_in   (req_in),
        .timer_hit(timer_hit),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .pend_q   (pending)
    );

    irq_level_search #(
        .NUM_LINES (NUM_LINES),
        .NUM_LEVELS(NUM_LEVELS),
        .NMI_LEVEL (NMI_LEVEL),
        .LINE_LEVEL(LINE_LEVEL)
    ) srch_i (
        .pend     (pending),
        .enable   (en_q),
        .cur_level(cur_level),
        .lvl_nxt  (lvl_nxt),
        .floor_lvl(floor_lvl),
        .nmi_lines(nmi_lines)
    );

    // Next-state logic for the request machine.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            RES_IDLE:   if (lvl_nxt != '0) state_nxt = RES_ASSERT;  // go_assert
            RES_ASSERT: if (lvl_nxt == '0) state_nxt = RES_IDLE;    // go_idle
            default:    state_nxt = RES_IDLE;
        endcase
    end

    // State, level and enable registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RES_IDLE;
            irq_level <= '0;
            en_q      <= '0;
        end else begin
            state_q   <= state_nxt;
            irq_level <= lvl_nxt;
            if (en_we) en_q <= en_wdata;
        end
    end

    // Output decode.
    always_comb begin
        irq_req = (state_q == RES_ASSERT);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (irq_level == '0 && pending == '0 && en_q == '0 && !irq_req));

    assert_nmi_resolves_R3: assert property (@(posedge clk) disable iff (rst)
        ((pending & nmi_lines) != '0) |=> (irq_level >= LVL_W'(NMI_LEVEL)));

    assert_above_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> (irq_level > $past(floor_lvl)));

    assert_idle_when_none_R4: assert property (@(posedge clk) disable iff (rst)
        (pending == '0) |=> (irq_level == '0));

    assert_req_tracks_level_R5: assert property (@(posedge clk) disable iff (rst)
        irq_req == (irq_level != '0));
endmodule

// File: tb/irq_level_resolver_tb.sv
module irq_level_resolver_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] req_in;
    logic [1:0] timer_hit;
    logic       en_we;
    logic [7:0] en_wdata;
    logic       clr_we;
    logic [7:0] clr_mask;
    logic [3:0] cur_level;
    logic [7:0] pending;
    logic [3:0] irq_level;
    logic       irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_level_resolver dut_i (
        .clk(clk), .rst(rst), .req_in(req_in), .timer_hit(timer_hit),
        .en_we(en_we), .en_wdata(en_wdata), .clr_we(clr_we), .clr_mask(clr_mask),
        .cur_level(cur_level), .pending(pending), .irq_level(irq_level), .irq_req(irq_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_en(input logic [7:0] v);
        en_we = 1'b1; en_wdata = v;
        tick(1);
        en_we = 1'b0;
    endtask

    task automatic pulse_clr(input logic [7:0] m);
        clr_we = 1'b1; clr_mask = m;
        tick(1);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic t_reset;
        check("R1 pending", 32'(pending), 32'h0);
        check("R1 level", 32'(irq_level), 32'h0);
        check("R1 irq_req", 32'(irq_req), 32'h0);
        req_in[0] = 1'b1;              // enable was cleared by reset
        tick(2);
        check("R6 level line set", 32'(pending), 32'h01);
        check("R1 enable cleared", 32'(irq_req), 32'h0);
        req_in[0] = 1'b0;
        tick(2);
    endtask

    task automatic t_enable_gate;
        req_in[2] = 1'b1;
        tick(2);
        check("R2 disabled pending", 32'(pending), 32'h04);
        check("R2 disabled level", 32'(irq_level), 32'h0);
        write_en(8'h04);
        tick(1);
        check("R2 enabled level", 32'(irq_level), 32'h2);
        check("R5 irq_req high", 32'(irq_req), 32'h1);
    endtask

    task automatic t_priority;
        write_en(8'hFF);
        req_in[4] = 1'b1;
        tick(2);
        check("R4 highest wins", 32'(irq_level), 32'h4);
        cur_level = 4'd4;
        tick(2);
        check("R4 strictly above", 32'(irq_level), 32'h0);
        check("R5 irq_req low", 32'(irq_req), 32'h0);
        cur_level = 4'd3;
        tick(2);
        check("R4 above cur 3", 32'(irq_level), 32'h4);
        cur_level = 4'd1;
        req_in[4] = 1'b0;
        tick(2);
        check("R4 fallback level", 32'(irq_level), 32'h2);
        req_in[2] = 1'b0;
        tick(1);
        check("R6 level line drop", 32'(pending), 32'h00);
        tick(1);
        check("R4 none left", 32'(irq_level), 32'h0);
        cur_level = 4'd0;
    endtask

    task automatic t_latency;
        req_in[3] = 1'b1;
        tick(1);
        check("R11 pending after one edge", 32'(pending), 32'h08);
        check("R11 irq not yet", 32'(irq_req), 32'h0);
        tick(1);
        check("R11 level next edge", 32'(irq_level), 32'h3);
        check("R11 irq next edge", 32'(irq_req), 32'h1);
        req_in[3] = 1'b0;
        tick(2);
    endtask

    task automatic t_edge;
        req_in[1] = 1'b1;
        tick(1);
        req_in[1] = 1'b0;
        tick(1);
        check("R7 edge sticky", 32'(pending), 32'h02);
        check("R7 edge level", 32'(irq_level), 32'h1);
        pulse_clr(8'h02);
        check("R8 clear", 32'(pending), 32'h00);
        req_in[7] = 1'b1; clr_we = 1'b1; clr_mask = 8'h80;
        tick(1);
        check("R8 set beats clear", 32'(pending), 32'h80);
        tick(1);   // request still high, no new rise
        check("R8 clear while held", 32'(pending), 32'h00);
        clr_we = 1'b0; clr_mask = '0; req_in[7] = 1'b0;
        tick(2);
    endtask

    task automatic t_nmi;
        write_en(8'h00);
        cur_level = 4'd15;
        req_in[5] = 1'b1;
        tick(2);
        check("R3 nmi above clamp", 32'(irq_level), 32'h5);
        check("R2 nmi bypasses enable", 32'(irq_req), 32'h1);
        cur_level = 4'd4;
        req_in[5] = 1'b0;
        tick(2);
        check("R6 nmi level line drop", 32'(irq_level), 32'h0);
        cur_level = 4'd0;
    endtask

    task automatic t_timer;
        write_en(8'hFF);
        timer_hit = 2'b01;
        tick(1);
        timer_hit = 2'b00;
        check("R9 timer0 line6", 32'(pending), 32'h40);
        tick(1);
        check("R9 timer0 level", 32'(irq_level), 32'h2);
        timer_hit = 2'b10;
        tick(1);
        timer_hit = 2'b00;
        check("R9 timer1 line7", 32'(pending), 32'hC0);
        tick(1);
        check("R9 timer1 level", 32'(irq_level), 32'h3);
        pulse_clr(8'hC0);
        tick(1);
        check("R8 timers acked", 32'(irq_level), 32'h0);
    endtask

    task automatic t_out_of_range;
        req_in[0] = 1'b1;
        tick(2);
        for (int k = 0; k < 4; k++) begin
            req_in[9:8] = 2'(k + 1);
            tick(1);
            check("R10 pending unchanged", 32'(pending), 32'h01);
            check("R10 level unchanged", 32'(irq_level), 32'h1);
        end
        req_in = '0;
        tick(2);
    endtask

    initial begin
        rst = 1'b1; req_in = '0; timer_hit = '0; en_we = 1'b0; en_wdata = '0;
        clr_we = 1'b0; clr_mask = '0; cur_level = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_enable_gate();
        t_priority();
        t_latency();
        t_edge();
        t_nmi();
        t_timer();
        t_out_of_range();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule